// File: doc/BRIEF.md
# Integer Execution Unit with Barrel Shifter

This block is the combinational integer execution stage of a three-operand load/store RISC core. The decode stage hands it a 6-bit function code, the two register operands read from the register file and the 5-bit constant shift amount taken from the instruction word. In the same cycle the block returns the computed word, a flag that reports a signed-overflow exception, and a commit strobe. The commit strobe tells the register file whether the destination may be written.

Four kinds of work share the unit: two's-complement add and subtract, bitwise logic, barrel shifts, and signed or unsigned less-than comparison. Add and subtract each come in two forms. The trapping form raises the exception and holds back the write on signed overflow. The plain form wraps silently. Shifts always act on the second operand. The amount comes either from the instruction field or from the low five bits of the first operand. A function code outside the supported set is rejected without touching the register file.

Top module: `int_exec_unit`

## Requirements
- R1: Codes 0x20 and 0x21 give `op_rs + op_rt`, and codes 0x22 and 0x23 give `op_rs - op_rt`, all modulo 2^32.
- R2: For codes 0x20 and 0x22, a result outside the signed 32-bit range sets `ovf_trap` to 1 and `wr_en` to 0. Without overflow, `ovf_trap` is 0 and `wr_en` is 1.
- R3: Codes 0x21 and 0x23 never set `ovf_trap`, and they always set `wr_en`, even when the signed result wraps.
- R4: Codes 0x24, 0x25, 0x26 and 0x27 give the bitwise AND, OR, XOR and NOR of the two operands. For example, 0xabcd1234 and 0xffff0000 give 0xabcd0000, 0xffff1234, 0x54321234 and 0x0000edcb.
- R5: Codes 0x00 (shift left) and 0x02 (logical right shift) shift `op_rt` by `shamt`, and `op_rs` has no effect on them. An amount of 0 passes `op_rt` through unchanged.
- R6: Codes 0x04, 0x06 and 0x07 shift `op_rt` by `op_rs[4:0]`, with the same direction and fill as 0x00, 0x02 and 0x03. Bits `op_rs[31:5]` and `shamt` have no effect. For example, 0xabcd1234 shifted right logically by 16 gives 0x0000abcd.
- R7: Codes 0x03 and 0x07 fill the vacated upper bits with `op_rt[31]`, while the left and logical-right shifts fill with zero. For example, 0xabcd1234 shifted arithmetically by 4 gives 0xfabcd123.
- R8: Code 0x2a gives 1 when `op_rs < op_rt` as signed numbers and 0 otherwise. Code 0x2b does the same comparison on unsigned numbers. For 1 against 0xffffffff, 0x2a gives 0 and 0x2b gives 1.
- R9: Any other function code drives `result` to 0, `wr_en` to 0, `ovf_trap` to 0 and `illegal_op` to 1. Every supported code drives `illegal_op` to 0, and every supported code except a trapping overflow drives `wr_en` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| funct | input | 6 | Function code selecting the operation |
| op_rs | input | 32 | First register operand; amount source for variable shifts |
| op_rt | input | 32 | Second register operand; the value shifted by all shifts |
| shamt | input | 5 | Constant shift amount from the instruction word |
| result | output | 32 | Computed word |
| ovf_trap | output | 1 | Signed-overflow exception from a trapping add or subtract |
| wr_en | output | 1 | Destination may be committed |
| illegal_op | output | 1 | Function code not supported |

## Verification
Immediate assertions inside the RTL check these relations on every evaluation: an overflow exception always blocks the commit, a plain add or subtract never raises the exception, a rejected code stays silent, and a comparison yields only 0 or 1. They also check that a zero-amount shift is the identity, that an arithmetic right shift keeps the sign, that the logic lanes agree with one another, and that the unsigned borrow matches a direct magnitude compare. Only the bench's sweep can show the exact values. It runs every one of the 64 function codes against operand pairs that sit on the signed and unsigned boundaries, with several shift amounts. This shows the correct wrapped sums and the exact overflow boundaries. It also shows that the upper bits of the variable-shift amount are ignored and that the known worked values come out right.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int FN_W = 6;

    typedef enum logic [FN_W-1:0] {
        FN_SLL  = 6'h00,
        FN_SRL  = 6'h02,
        FN_SRA  = 6'h03,
        FN_SLLV = 6'h04,
        FN_SRLV = 6'h06,
        FN_SRAV = 6'h07,
        FN_ADD  = 6'h20,
        FN_ADDU = 6'h21,
        FN_SUB  = 6'h22,
        FN_SUBU = 6'h23,
        FN_AND  = 6'h24,
        FN_OR   = 6'h25,
        FN_XOR  = 6'h26,
        FN_NOR  = 6'h27,
        FN_SLT  = 6'h2a,
        FN_SLTU = 6'h2b
    } fn_code_e;

    typedef enum logic [2:0] {
        UNIT_NONE,
        UNIT_ARITH,
        UNIT_LOGIC,
        UNIT_SHIFT,
        UNIT_CMP
    } unit_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2,
        LG_NOR = 2'd3
    } logic_e;

    typedef enum logic [1:0] {
        SH_LEFT,
        SH_RIGHT_ZERO,
        SH_RIGHT_SIGN
    } shift_e;

    typedef struct packed {
        unit_e  unit;
        logic   subtract;
        logic   trap_en;
        logic_e lg;
        shift_e sh;
        logic   amt_from_reg;
        logic   cmp_unsigned;
    } ctrl_t;

    function automatic ctrl_t decode_fn(input logic [FN_W-1:0] fn);
        ctrl_t c;
        c = '{unit: UNIT_NONE, subtract: 1'b0, trap_en: 1'b0, lg: LG_AND,
              sh: SH_LEFT, amt_from_reg: 1'b0, cmp_unsigned: 1'b0};
        case (fn)
            FN_ADD:  begin c.unit = UNIT_ARITH; c.trap_en = 1'b1; end
            FN_ADDU: begin c.unit = UNIT_ARITH; end
            FN_SUB:  begin c.unit = UNIT_ARITH; c.trap_en = 1'b1; c.subtract = 1'b1; end
            FN_SUBU: begin c.unit = UNIT_ARITH; c.subtract = 1'b1; end
            FN_AND, FN_OR, FN_XOR, FN_NOR:
                     begin c.unit = UNIT_LOGIC; c.lg = logic_e'(fn[1:0]); end
            FN_SLL:  begin c.unit = UNIT_SHIFT; c.sh = SH_LEFT; end
            FN_SRL:  begin c.unit = UNIT_SHIFT; c.sh = SH_RIGHT_ZERO; end
            FN_SRA:  begin c.unit = UNIT_SHIFT; c.sh = SH_RIGHT_SIGN; end
            FN_SLLV: begin c.unit = UNIT_SHIFT; c.sh = SH_LEFT; c.amt_from_reg = 1'b1; end
            FN_SRLV: begin c.unit = UNIT_SHIFT; c.sh = SH_RIGHT_ZERO; c.amt_from_reg = 1'b1; end
            FN_SRAV: begin c.unit = UNIT_SHIFT; c.sh = SH_RIGHT_SIGN; c.amt_from_reg = 1'b1; end
            FN_SLT:  begin c.unit = UNIT_CMP; c.subtract = 1'b1; end
            FN_SLTU: begin c.unit = UNIT_CMP; c.subtract = 1'b1; c.cmp_unsigned = 1'b1; end
            default: c.unit = UNIT_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/alu_decode.sv
module alu_decode
    import alu_pkg::*;
(
    input  logic [FN_W-1:0] fn,
    output ctrl_t           ctrl,
    output logic            bad_code
);

    always_comb begin
        ctrl     = decode_fn(fn);
        bad_code = (ctrl.unit == UNIT_NONE);
    end

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         signed_ovf,
    output logic         lt_signed,
    output logic         lt_unsigned
);

    logic [W-1:0] b_eff;
    logic [W:0]   wide;

    always_comb begin
        b_eff       = sub ? ~b : b;
        wide        = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
        sum         = wide[W-1:0];
        signed_ovf  = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
        lt_unsigned = ~wide[W];
        lt_signed   = (a[W-1] ^ b[W-1]) ? a[W-1] : sum[W-1];
    end

    // borrow out must agree with a direct magnitude compare (R8)
    always_comb begin
        if (sub) begin
            assert_borrow_is_ltu_R8: assert (lt_unsigned == (a < b));
        end
    end

endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic_e       sel,
    output logic [W-1:0] y
);

    logic [W-1:0] and_v, or_v, xor_v, nor_v;

    always_comb begin
        and_v = a & b;
        or_v  = a | b;
        xor_v = a ^ b;
        nor_v = ~or_v;
        case (sel)
            LG_AND:  y = and_v;
            LG_OR:   y = or_v;
            LG_XOR:  y = xor_v;
            default: y = nor_v;
        endcase
    end

    // independent lanes must be mutually consistent (R4)
    always_comb begin
        assert_lane_identity_R4: assert (((and_v ^ xor_v) == ~nor_v) && ((and_v & xor_v) == '0));
    end

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]         din,
    input  logic [$clog2(W)-1:0] amt,
    input  shift_e               mode,
    output logic [W-1:0]         dout
);

    localparam int SW = $clog2(W);

    logic [SW:0][W-1:0] stage;

    assign stage[0] = din;

    for (genvar k = 0; k < SW; k++) begin : g_stage
        localparam int STEP = 1 << k;
        logic [W-1:0] nxt;
        assign nxt = (mode == SH_LEFT)       ? {stage[k][W-1-STEP:0], {STEP{1'b0}}} :
                     (mode == SH_RIGHT_SIGN) ? {{STEP{stage[k][W-1]}}, stage[k][W-1:STEP]} :
                                               {{STEP{1'b0}}, stage[k][W-1:STEP]};
        assign stage[k+1] = amt[k] ? nxt : stage[k];
    end

    assign dout = stage[SW];

    always_comb begin
        if (amt == '0) begin
            assert_zero_amount_identity_R5: assert (dout == din);
        end
        if (mode == SH_RIGHT_SIGN) begin
            assert_sign_kept_R7: assert (dout[W-1] == din[W-1]);
        end
    end

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
    import alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [FN_W-1:0]           funct,
    input  logic [DATA_W-1:0]         op_rs,
    input  logic [DATA_W-1:0]         op_rt,
    input  logic [$clog2(DATA_W)-1:0] shamt,
    output logic [DATA_W-1:0]         result,
    output logic                      ovf_trap,
    output logic                      wr_en,
    output logic                      illegal_op
);

    localparam int SH_W = $clog2(DATA_W);

    ctrl_t             ctrl;
    logic              bad_code;
    logic [DATA_W-1:0] sum_v, logic_v, shift_v;
    logic              add_ovf, lt_s, lt_u;
    logic [SH_W-1:0]   sh_amt;

    alu_decode u_decode (
        .fn       (funct),
        .ctrl     (ctrl),
        .bad_code (bad_code)
    );

    alu_addsub #(.W(DATA_W)) u_addsub (
        .a           (op_rs),
        .b           (op_rt),
        .sub         (ctrl.subtract),
        .sum         (sum_v),
        .signed_ovf  (add_ovf),
        .lt_signed   (lt_s),
        .lt_unsigned (lt_u)
    );

    alu_logic #(.W(DATA_W)) u_logic (
        .a   (op_rs),
        .b   (op_rt),
        .sel (ctrl.lg),
        .y   (logic_v)
    );

    assign sh_amt = ctrl.amt_from_reg ? op_rs[SH_W-1:0] : shamt;

    alu_shifter #(.W(DATA_W)) u_shift (
        .din  (op_rt),
        .amt  (sh_amt),
        .mode (ctrl.sh),
        .dout (shift_v)
    );

    always_comb begin
        case (ctrl.unit)
            UNIT_ARITH: result = sum_v;
            UNIT_LOGIC: result = logic_v;
            UNIT_SHIFT: result = shift_v;
            UNIT_CMP:   result = {{(DATA_W-1){1'b0}}, ctrl.cmp_unsigned ? lt_u : lt_s};
            default:    result = '0;
        endcase
        ovf_trap   = (ctrl.unit == UNIT_ARITH) && ctrl.trap_en && add_ovf;
        illegal_op = bad_code;
        wr_en      = !bad_code && !ovf_trap;
    end

    always_comb begin
        if (ovf_trap) begin
            assert_trap_blocks_write_R2: assert (!wr_en);
        end
        if (!ctrl.trap_en) begin
            assert_plain_never_traps_R3: assert (!ovf_trap);
        end
        if (illegal_op) begin
            assert_rejected_is_quiet_R9: assert (result == '0 && !wr_en && !ovf_trap);
        end
        if (ctrl.unit == UNIT_CMP) begin
            assert_compare_is_boolean_R8: assert (result[DATA_W-1:1] == '0);
        end
    end

endmodule

// File: tb/int_exec_unit_tb.sv
module int_exec_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  funct = '0;
    logic [31:0] op_rs = '0;
    logic [31:0] op_rt = '0;
    logic [4:0]  shamt = '0;
    logic [31:0] result;
    logic        ovf_trap, wr_en, illegal_op;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    localparam longint S_MAX = 64'sh7FFF_FFFF;
    localparam longint S_MIN = -64'sh8000_0000;

    always #10 clk = ~clk;

    int_exec_unit dut_i (
        .funct      (funct),
        .op_rs      (op_rs),
        .op_rt      (op_rt),
        .shamt      (shamt),
        .result     (result),
        .ovf_trap   (ovf_trap),
        .wr_en      (wr_en),
        .illegal_op (illegal_op)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic void model(input logic [5:0] fn, input logic [31:0] a, input logic [31:0] b,
                                  input logic [4:0] sa, output logic [31:0] r, output logic ov,
                                  output logic we, output logic il);
        longint s;
        r = '0; ov = 1'b0; we = 1'b1; il = 1'b0;
        case (fn)
            6'h20: begin r = a + b; s = longint'($signed(a)) + longint'($signed(b)); ov = (s > S_MAX) || (s < S_MIN); end
            6'h21: r = a + b;
            6'h22: begin r = a - b; s = longint'($signed(a)) - longint'($signed(b)); ov = (s > S_MAX) || (s < S_MIN); end
            6'h23: r = a - b;
            6'h24: r = a & b;
            6'h25: r = a | b;
            6'h26: r = a ^ b;
            6'h27: r = ~(a | b);
            6'h00: r = b << sa;
            6'h02: r = b >> sa;
            6'h03: r = $unsigned($signed(b) >>> sa);
            6'h04: r = b << a[4:0];
            6'h06: r = b >> a[4:0];
            6'h07: r = $unsigned($signed(b) >>> a[4:0]);
            6'h2a: r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            6'h2b: r = (a < b) ? 32'd1 : 32'd0;
            default: begin we = 1'b0; il = 1'b1; end
        endcase
        if (ov) we = 1'b0;
    endfunction

    function automatic string res_tag(input logic [5:0] fn);
        case (fn)
            6'h20, 6'h21, 6'h22, 6'h23: return "R1";
            6'h24, 6'h25, 6'h26, 6'h27: return "R4";
            6'h00, 6'h02:               return "R5";
            6'h03, 6'h07:               return "R7";
            6'h04, 6'h06:               return "R6";
            6'h2a, 6'h2b:               return "R8";
            default:                    return "R9";
        endcase
    endfunction

    function automatic string flag_tag(input logic [5:0] fn);
        case (fn)
            6'h20, 6'h22: return "R2";
            6'h21, 6'h23: return "R3";
            default:      return "R9";
        endcase
    endfunction

    task automatic run(input logic [5:0] fn, input logic [31:0] a, input logic [31:0] b, input logic [4:0] sa);
        logic [31:0] er;
        logic eo, ew, ei;
        @(posedge clk);
        funct = fn; op_rs = a; op_rt = b; shamt = sa;
        @(negedge clk);
        model(fn, a, b, sa, er, eo, ew, ei);
        chk(res_tag(fn), "result", result, er);
        chk(flag_tag(fn), "ovf_trap", {31'd0, ovf_trap}, {31'd0, eo});
        chk(flag_tag(fn), "wr_en", {31'd0, wr_en}, {31'd0, ew});
        chk("R9", "illegal_op", {31'd0, illegal_op}, {31'd0, ei});
    endtask

    task automatic expect_val(input string tag, input logic [5:0] fn, input logic [31:0] a,
                              input logic [31:0] b, input logic [4:0] sa, input logic [31:0] exp);
        @(posedge clk);
        funct = fn; op_rs = a; op_rt = b; shamt = sa;
        @(negedge clk);
        chk(tag, "directed", result, exp);
    endtask

    logic [31:0] pa [12];
    logic [31:0] pb [12];
    logic [4:0]  sav [6];

    initial begin
        pa[0]  = 32'habcd1234; pb[0]  = 32'hffff0000;
        pa[1]  = 32'h00000001; pb[1]  = 32'hffffffff;
        pa[2]  = 32'h7fffffff; pb[2]  = 32'h00000001;
        pa[3]  = 32'h80000000; pb[3]  = 32'h00000001;
        pa[4]  = 32'h80000000; pb[4]  = 32'h80000000;
        pa[5]  = 32'h00000000; pb[5]  = 32'h00000000;
        pa[6]  = 32'hffffff10; pb[6]  = 32'habcd1234;
        pa[7]  = 32'h7fffffff; pb[7]  = 32'hffffffff;
        pa[8]  = 32'h8000000c; pb[8]  = 32'h80000001;
        pa[9]  = 32'h12345678; pb[9]  = 32'h12345678;
        pa[10] = 32'hfffffffe; pb[10] = 32'h7fffffff;
        pa[11] = 32'h0000003f; pb[11] = 32'h5a5a5a5a;
        sav[0] = 5'd0; sav[1] = 5'd1; sav[2] = 5'd4;
        sav[3] = 5'd8; sav[4] = 5'd16; sav[5] = 5'd31;

        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // idle inputs (code 0, zero operands): a shift of zero by zero
        chk("R5", "idle result", result, 32'd0);
        chk("R9", "idle illegal", {31'd0, illegal_op}, 32'd0);

        for (int f = 0; f < 64; f++)
            for (int p = 0; p < 12; p++)
                for (int s = 0; s < 6; s++)
                    run(6'(f), pa[p], pb[p], sav[s]);

        // worked values
        expect_val("R4", 6'h24, 32'habcd1234, 32'hffff0000, 5'd0, 32'habcd0000);
        expect_val("R4", 6'h25, 32'habcd1234, 32'hffff0000, 5'd0, 32'hffff1234);
        expect_val("R4", 6'h26, 32'habcd1234, 32'hffff0000, 5'd0, 32'h54321234);
        expect_val("R4", 6'h27, 32'habcd1234, 32'hffff0000, 5'd0, 32'h0000edcb);
        expect_val("R5", 6'h00, 32'h0, 32'habcd1234, 5'd8, 32'hcd123400);
        expect_val("R5", 6'h02, 32'hffffffff, 32'habcd1234, 5'd4, 32'h0abcd123);
        expect_val("R7", 6'h03, 32'h0, 32'habcd1234, 5'd4, 32'hfabcd123);
        expect_val("R6", 6'h06, 32'h00000010, 32'habcd1234, 5'd3, 32'h0000abcd);
        expect_val("R6", 6'h06, 32'hffffffd0, 32'habcd1234, 5'd0, 32'h0000abcd);
        expect_val("R8", 6'h2a, 32'h1, 32'hffffffff, 5'd0, 32'd0);
        expect_val("R8", 6'h2b, 32'h1, 32'hffffffff, 5'd0, 32'd1);
        expect_val("R1", 6'h21, 32'hffffffff, 32'h1, 5'd0, 32'd0);

        // overflow boundary: trapping add at max+1, plain add wraps
        @(posedge clk);
        funct = 6'h20; op_rs = 32'h7fffffff; op_rt = 32'h1;
        @(negedge clk);
        chk("R2", "add overflow trap", {31'd0, ovf_trap}, 32'd1);
        chk("R2", "add overflow no write", {31'd0, wr_en}, 32'd0);
        @(posedge clk);
        funct = 6'h23; op_rs = 32'h80000000; op_rt = 32'h1;
        @(negedge clk);
        chk("R3", "subu wraps without trap", {31'd0, ovf_trap}, 32'd0);
        chk("R3", "subu writes", {31'd0, wr_en}, 32'd1);
        chk("R3", "subu value", result, 32'h7fffffff);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule